// File: doc/BRIEF.md
# Fan Tachometer Period Meter

This block measures the speed of one fan at a time out of a bank of tachometer inputs. Software starts a measurement on channel n by making bit n of the trigger vector go from 0 to 1. Each channel names one of eight PWM ports through a three-bit source select. That port picks one of several profile words. The chosen profile sets the qualifying edge type, the tach clock divisor and an arming window.

The selected input is synchronized and its qualifying edges are detected. The block then counts divided-clock ticks from one qualifying edge to the next. The count is posted with a done flag in a 32-bit result word, which software polls. Turning the count into RPM is left to software.

Top module: `tach_meter`

## Requirements
- R1: While reset is active the result word is zero and no measurement is in progress.
- R2: A measurement on channel n starts only on a 0-to-1 transition of trigReg[n]. A bit held high does not restart it. When several bits rise in the same cycle, the lowest index is measured. The start clears the whole result word, including the done flag.
- R3: The source port of channel n is {srcHi[2n], srcLo[2n+1:2n]}. Port p takes its profile index from portProf[2p+1:2p]. An index of NPROF or more selects profile 0.
- R4: Profile word layout: bit 0 enables, bits 3:1 hold the divider code, bits 5:4 hold the edge type, and bits 31:16 hold the arming window. All other bits are ignored.
- R5: Edge type 00 qualifies falling transitions, 01 rising, and 10 both. The reserved code 11 behaves like 10.
- R6: The tick divisor is 4 << (2*div). The posted count is max(1, floor(K/D)), where K is the number of clocks between two consecutive qualifying transitions. In both-edge mode this spans half a period.
- R7: Result bit 31 is done and bits 19:0 are the zero-extended count. Bits 30:20 are zero, and the count is zero while done is clear. A posted result holds until the next start.
- R8: If the count reaches its all-ones value before the second edge, all-ones is posted with done set.
- R9: With a nonzero window, if no first edge arrives within that many ticks, all-ones is posted with done set. A window of 0 waits indefinitely.
- R10: While chanEnable[n] or the profile enable bit is low, the measurement on channel n is frozen and never completes. It resumes once the enable returns.
- R11: A posted result with done set never carries a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tachIn | input | NCH | Raw tachometer inputs |
| trigReg | input | NCH | Trigger vector, one bit per channel |
| chanEnable | input | NCH | Per-channel enables |
| srcLo | input | 2*NCH | Source select bits 1:0, two per channel |
| srcHi | input | 2*NCH | Source select bit 2, at even positions |
| portProf | input | 8*PSEL_W | Profile index per PWM port |
| profWords | input | NPROF*32 | Profile control words |
| result | output | 32 | Done flag and count |

## Verification
The bench builds the block with four channels, three profiles and an 8-bit counter. The narrow counter lets saturation at 255 happen in about a thousand clocks, and the four channels keep source-select packing and trigger priority visible. The divider codes used are 0 and 1, which give tick divisors of 4 and 16. Short, symmetric and asymmetric tach waveforms exercise each edge type, the never-zero rule and the arming window.

// File: rtl/tach_pkg.sv
package tach_pkg;
  localparam int PROF_W       = 32;
  localparam int SRC_W        = 3;
  localparam int NPORT        = 1 << SRC_W;
  localparam int RES_CNT_W    = 20;
  localparam int PRE_W        = 17;
  localparam int PROF_EN_BIT  = 0;
  localparam int PROF_DIV_LSB = 1;
  localparam int PROF_MODE_LSB = 4;
  localparam int PROF_WIN_LSB = 16;

  typedef enum logic [1:0] {EDGE_FALL = 2'b00, EDGE_RISE = 2'b01, EDGE_BOTH = 2'b10, EDGE_RSVD = 2'b11} edgeMode_t;
  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_COUNT} measState_t;

  typedef struct packed {
    logic start;
    logic restartPre;
    logic run;
    logic postCount;
    logic postSat;
  } tachStrobe_t;

  typedef struct packed {
    logic qualEdge;
    logic armExpired;
    logic cntFull;
  } tachStatus_t;

  function automatic logic [PRE_W-1:0] tickDivisor(input logic [2:0] d);
    return PRE_W'(4) << (2 * int'(d));
  endfunction
endpackage

// File: rtl/tach_control.sv
module tach_control import tach_pkg::*; #(
  parameter int NCH    = 16,
  parameter int NPROF  = 3,
  parameter int CH_W   = 4,
  parameter int PSEL_W = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NCH-1:0]          trigReg,
  input  logic [NCH-1:0]          chanEnable,
  input  logic [2*NCH-1:0]        srcLo,
  input  logic [2*NCH-1:0]        srcHi,
  input  logic [NPORT*PSEL_W-1:0] portProf,
  input  logic [NPROF*PROF_W-1:0] profWords,
  input  tachStatus_t             status,
  output tachStrobe_t             strobe,
  output logic [CH_W-1:0]         curCh,
  output edgeMode_t               curMode,
  output logic [2:0]              curDiv,
  output logic [15:0]             curWin
);
  logic [NCH-1:0]    trigPrev;
  logic [NCH-1:0]    rise;
  logic              anyRise;
  logic [CH_W-1:0]   pick;
  logic [SRC_W-1:0]  pickSrc;
  logic [PSEL_W-1:0] pickProf;
  logic [PSEL_W-1:0] profIdx;
  logic [PROF_W-1:0] pickWord;
  logic              profEn;
  logic              gate;
  measState_t        state;
  logic [NCH-1:0]    unusedOddHi;

  always_comb begin
    for (int i = 0; i < NCH; i++) unusedOddHi[i] = srcHi[2*i+1];
  end

  always_comb begin
    rise    = trigReg & ~trigPrev;
    anyRise = |rise;
    pick    = '0;
    for (int i = NCH - 1; i >= 0; i--) if (rise[i]) pick = CH_W'(i);
    pickSrc  = {srcHi[2*int'(pick)], srcLo[2*int'(pick) +: 2]};
    pickProf = portProf[int'(pickSrc)*PSEL_W +: PSEL_W];
    profIdx  = (int'(pickProf) < NPROF) ? pickProf : '0;
    pickWord = profWords[int'(profIdx)*PROF_W +: PROF_W];
  end

  assign gate = chanEnable[curCh] & profEn;

  always_comb begin
    strobe = '0;
    if (anyRise) strobe.start = 1'b1;
    else if (gate) begin
      unique case (state)
        ST_ARM: begin
          if (status.qualEdge)        strobe.restartPre = 1'b1;
          else if (status.armExpired) strobe.postSat = 1'b1;
          else                        strobe.run = 1'b1;
        end
        ST_COUNT: begin
          if (status.qualEdge)     strobe.postCount = 1'b1;
          else if (status.cntFull) strobe.postSat = 1'b1;
          else                     strobe.run = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigPrev <= '0;
      state    <= ST_IDLE;
      curCh    <= '0;
      curMode  <= EDGE_FALL;
      curDiv   <= '0;
      curWin   <= '0;
      profEn   <= 1'b0;
    end else begin
      trigPrev <= trigReg;
      if (strobe.start) begin
        state   <= ST_ARM;
        curCh   <= pick;
        curMode <= edgeMode_t'(pickWord[PROF_MODE_LSB +: 2]);
        curDiv  <= pickWord[PROF_DIV_LSB +: 3];
        curWin  <= pickWord[PROF_WIN_LSB +: 16];
        profEn  <= pickWord[PROF_EN_BIT];
      end else if (strobe.restartPre) state <= ST_COUNT;
      else if (strobe.postCount || strobe.postSat) state <= ST_IDLE;
    end
  end
endmodule

// File: rtl/tach_datapath.sv
module tach_datapath import tach_pkg::*; #(
  parameter int NCH   = 16,
  parameter int CNT_W = 20,
  parameter int CH_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NCH-1:0]   tachIn,
  input  tachStrobe_t      strobe,
  input  logic [CH_W-1:0]  curCh,
  input  edgeMode_t        curMode,
  input  logic [2:0]       curDiv,
  input  logic [15:0]      curWin,
  output tachStatus_t      status,
  output logic [31:0]      result
);
  logic [NCH-1:0]   syncA, syncB, prevB;
  logic             selRise, selFall, tick;
  logic [PRE_W-1:0] pre, divisor;
  logic [15:0]      armCnt;
  logic [CNT_W-1:0] cnt, cntOut;
  logic             doneR;

  for (genvar g = 0; g < NCH; g++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA[g] <= 1'b0;
        syncB[g] <= 1'b0;
        prevB[g] <= 1'b0;
      end else begin
        syncA[g] <= tachIn[g];
        syncB[g] <= syncA[g];
        prevB[g] <= syncB[g];
      end
    end
  end

  assign selRise = syncB[curCh] & ~prevB[curCh];
  assign selFall = ~syncB[curCh] & prevB[curCh];
  assign divisor = tickDivisor(curDiv);
  assign tick    = strobe.run && (pre == divisor - PRE_W'(1));

  always_comb begin
    unique case (curMode)
      EDGE_FALL: status.qualEdge = selFall;
      EDGE_RISE: status.qualEdge = selRise;
      default:   status.qualEdge = selRise | selFall;
    endcase
    status.armExpired = (curWin != '0) && (armCnt >= curWin);
    status.cntFull    = &cnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pre    <= '0;
      armCnt <= '0;
      cnt    <= '0;
    end else if (strobe.start) begin
      pre    <= '0;
      armCnt <= '0;
      cnt    <= '0;
    end else if (strobe.restartPre) begin
      pre <= PRE_W'(1);
      cnt <= '0;
    end else if (strobe.run) begin
      pre <= tick ? '0 : pre + PRE_W'(1);
      if (tick) begin
        cnt <= cnt + CNT_W'(1);
        if (armCnt != '1) armCnt <= armCnt + 16'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneR  <= 1'b0;
      cntOut <= '0;
    end else if (strobe.start) begin
      doneR  <= 1'b0;
      cntOut <= '0;
    end else if (strobe.postCount) begin
      doneR  <= 1'b1;
      cntOut <= (cnt == '0) ? CNT_W'(1) : cnt;
    end else if (strobe.postSat) begin
      doneR  <= 1'b1;
      cntOut <= '1;
    end
  end

  assign result = {doneR, 11'd0, RES_CNT_W'(cntOut)};
endmodule

// File: rtl/tach_meter.sv
module tach_meter import tach_pkg::*; #(
  parameter int NCH    = 16,
  parameter int NPROF  = 3,
  parameter int CNT_W  = 20,
  parameter int PSEL_W = (NPROF > 1) ? $clog2(NPROF) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NCH-1:0]          tachIn,
  input  logic [NCH-1:0]          trigReg,
  input  logic [NCH-1:0]          chanEnable,
  input  logic [2*NCH-1:0]        srcLo,
  input  logic [2*NCH-1:0]        srcHi,
  input  logic [NPORT*PSEL_W-1:0] portProf,
  input  logic [NPROF*32-1:0]     profWords,
  output logic [31:0]             result
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  tachStrobe_t     strobe;
  tachStatus_t     status;
  logic [CH_W-1:0] curCh;
  edgeMode_t       curMode;
  logic [2:0]      curDiv;
  logic [15:0]     curWin;

  tach_control #(.NCH(NCH), .NPROF(NPROF), .CH_W(CH_W), .PSEL_W(PSEL_W)) ctl_i (
    .clk(clk), .rstN(rstN), .trigReg(trigReg), .chanEnable(chanEnable),
    .srcLo(srcLo), .srcHi(srcHi), .portProf(portProf), .profWords(profWords),
    .status(status), .strobe(strobe), .curCh(curCh), .curMode(curMode),
    .curDiv(curDiv), .curWin(curWin));

  tach_datapath #(.NCH(NCH), .CNT_W(CNT_W), .CH_W(CH_W)) dp_i (
    .clk(clk), .rstN(rstN), .tachIn(tachIn), .strobe(strobe), .curCh(curCh),
    .curMode(curMode), .curDiv(curDiv), .curWin(curWin), .status(status),
    .result(result));
endmodule

// File: rtl/tach_meter_sva.sv
module tach_meter_sva #(
  parameter int NCH = 16
) (
  input logic           clk,
  input logic           rstN,
  input logic [NCH-1:0] trigReg,
  input logic [31:0]    result
);
  logic [NCH-1:0] prevTrig;
  logic           trigRose;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevTrig <= '0;
    else       prevTrig <= trigReg;
  end
  assign trigRose = |(trigReg & ~prevTrig);

  assert_reset_clear_R1: assert property (@(posedge clk) !rstN |-> result == 32'd0);

  assert_start_clears_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    trigRose |=> !result[31]);

  assert_result_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    (result[31] && !trigRose) |=> (result[31] && $stable(result)));

  assert_spare_bits_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    result[30:20] == 11'd0);

  assert_idle_count_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    !result[31] |-> result[19:0] == 20'd0);

  assert_no_zero_count_R11: assert property (@(posedge clk) disable iff (!rstN)
    result[31] |-> result[19:0] != 20'd0);
endmodule

bind tach_meter tach_meter_sva #(.NCH(NCH)) sva_i (
  .clk(clk), .rstN(rstN), .trigReg(trigReg), .result(result));

// File: tb/tach_meter_tb.sv
`timescale 1ns/1ps
module tach_meter_tb_top;
  localparam int NCH = 4;
  localparam int NPROF = 3;
  localparam int CNT_W = 8;
  localparam int PSEL_W = 2;
  localparam int NV = 7;
  // ch, src, psel, mode, div, hi, lo, expected count
  localparam int VEC [NV][8] = '{
    '{0, 0, 0, 0, 0, 10, 10, 5},     // R5 falling, R6 D=4
    '{1, 5, 1, 1, 1, 30, 34, 4},     // R5 rising, R6 D=16
    '{2, 6, 2, 2, 0, 12, 12, 3},     // R5 both edges half period, R3 bit 2 of source
    '{3, 3, 0, 0, 0, 1, 2, 1},       // R11 floor 0 reported as 1
    '{1, 2, 1, 3, 0, 20, 20, 5},     // R5 reserved code acts as both
    '{0, 7, 2, 1, 1, 100, 60, 10},   // R6 asymmetric waveform
    '{2, 4, 0, 0, 0, 600, 600, 255}  // R8 saturation
  };

  logic clk = 0, rstN = 0;
  logic [NCH-1:0] tachIn, trigReg = '0, chanEnable = '1;
  logic [2*NCH-1:0] srcLo = '0, srcHi = '0;
  logic [8*PSEL_W-1:0] portProf = '0;
  logic [NPROF*32-1:0] profWords = '0;
  logic [31:0] result;
  int hiLen[NCH], loLen[NCH], ph[NCH];
  logic [NCH-1:0] tachW = '0;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tach_meter #(.NCH(NCH), .NPROF(NPROF), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .tachIn(tachIn), .trigReg(trigReg), .chanEnable(chanEnable),
    .srcLo(srcLo), .srcHi(srcHi), .portProf(portProf), .profWords(profWords), .result(result));

  initial for (int i = 0; i < NCH; i++) begin hiLen[i] = 0; loLen[i] = 0; ph[i] = 0; end

  always @(negedge clk) begin
    for (int i = 0; i < NCH; i++) begin
      if (hiLen[i] == 0) begin tachW[i] = 1'b0; ph[i] = 0; end
      else begin
        ph[i]++;
        if (tachW[i] && ph[i] >= hiLen[i]) begin tachW[i] = 1'b0; ph[i] = 0; end
        else if (!tachW[i] && ph[i] >= loLen[i]) begin tachW[i] = 1'b1; ph[i] = 0; end
      end
    end
    tachIn = tachW;
  end

  function automatic logic [31:0] expWord(int c);
    return {1'b1, 11'd0, 20'(c)};
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfgChan(int ch, int src, int psel, int widx, int mode, int div,
                         int win, bit en, int hi, int lo);
    srcLo[2*ch +: 2] = 2'(src);
    srcHi[2*ch] = src[2];
    portProf[src*PSEL_W +: PSEL_W] = PSEL_W'(psel);
    profWords[widx*32 +: 32] = {16'(win), 10'd0, 2'(mode), 3'(div), en};
    hiLen[ch] = hi;
    loLen[ch] = lo;
    repeat (hi + lo + 6) @(negedge clk);
  endtask

  task automatic trig(logic [NCH-1:0] bits);
    trigReg = '0;
    @(negedge clk);
    trigReg = bits;
    @(negedge clk);
  endtask

  task automatic waitDone(int maxCyc);
    for (int i = 0; i < maxCyc && !result[31]; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(result == 32'd0, "R1 result during reset", result, 32'd0);
    rstN = 1;
    @(negedge clk);
    check(result == 32'd0, "R1 result after reset", result, 32'd0);

    for (int v = 0; v < NV; v++) begin
      cfgChan(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][2], VEC[v][3], VEC[v][4],
              0, 1'b1, VEC[v][5], VEC[v][6]);
      trig(NCH'(1) << VEC[v][0]);
      waitDone(6000);
      check(result == expWord(VEC[v][7]), $sformatf("R6 vector %0d", v), result, expWord(VEC[v][7]));
    end

    // R2: held trigger does not restart
    begin
      logic [31:0] r;
      r = result;
      repeat (100) @(negedge clk);
      check(result == r, "R2 held trigger", result, r);
    end

    // R2: new start clears done; ch0 still on port 7 -> profile 2 (rising, D=16)
    trig(4'b0001);
    check(result == 32'd0, "R2 start clears result", result, 32'd0);
    waitDone(3000);
    check(result == expWord(10), "R2 retrigger count", result, expWord(10));

    // R2: lowest index wins on simultaneous rise
    cfgChan(1, 1, 1, 1, 0, 0, 0, 1'b1, 10, 10);
    cfgChan(3, 3, 0, 0, 0, 0, 0, 1'b1, 30, 30);
    trig(4'b1010);
    waitDone(3000);
    check(result == expWord(5), "R2 priority", result, expWord(5));

    // R10: channel enable low freezes, resumes when set
    cfgChan(2, 6, 2, 2, 2, 0, 0, 1'b1, 12, 12);
    chanEnable[2] = 1'b0;
    trig(4'b0100);
    repeat (300) @(negedge clk);
    check(result[31] == 1'b0, "R10 channel disabled", result, 32'd0);
    chanEnable[2] = 1'b1;
    waitDone(1000);
    check(result == expWord(3), "R10 resume", result, expWord(3));

    // R10 / R4: profile enable bit low
    cfgChan(2, 6, 2, 2, 2, 0, 0, 1'b0, 12, 12);
    trig(4'b0100);
    repeat (300) @(negedge clk);
    check(result[31] == 1'b0, "R10 profile disabled", result, 32'd0);

    // R9: arming window expires on a static input
    cfgChan(3, 3, 0, 0, 0, 0, 2, 1'b1, 0, 0);
    trig(4'b1000);
    waitDone(100);
    check(result == expWord(255), "R9 window expiry", result, expWord(255));

    // R9: window 0 waits indefinitely
    cfgChan(3, 3, 0, 0, 0, 0, 0, 1'b1, 0, 0);
    trig(4'b1000);
    repeat (300) @(negedge clk);
    check(result[31] == 1'b0, "R9 zero window waits", result, 32'd0);

    // R3: profile index 3 (>= NPROF) falls back to profile 0
    cfgChan(0, 1, 3, 0, 0, 0, 0, 1'b1, 10, 10);
    trig(4'b0001);
    waitDone(3000);
    check(result == expWord(5), "R3 out-of-range profile", result, expWord(5));

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule